// File: doc/BRIEF.md
# Floppy Status Override Register

This block lets configuration software force the disk-change and write-protect status that a floppy controller sees, without touching the drive cable. It holds three override bits in one configuration byte. Two are sticky per-drive disk-change forces: software can set them, and only a step-with-deselect condition on the drive lines can clear them. The third forces write protection while any drive is selected.

Each disk-change force bit is a small two-state machine. The states are `FC_IDLE` (not forced) and `FC_FORCED` (forced). The `SET` transition, from `FC_IDLE` to `FC_FORCED`, happens on a configuration write with a 1 in that drive's bit when no clear condition is present. The `CLEAR` transition, from `FC_FORCED` to `FC_IDLE`, happens in any cycle where the step line and that drive's select line are both high. The `HOLD` transition keeps the state otherwise. Combinational status logic merges the forces with the drive pins to produce the disk-change input seen by the controller, bit 7 of the digital input register, and the internal write-protect input.

Top module: `fdc_status_override`

## Requirements
- R1: A configuration write with bit 0 (drive 0) or bit 1 (drive 1) at 1 sets that drive's force bit. The new value is visible in `cfg_rdata` after the next rising clock edge.
- R2: A configuration write with 0 in a force bit position leaves that force bit unchanged.
- R3: The drive i force bit clears on any rising edge where `step_n`=1 and `ds_n[i]`=1. When a clear and a set occur in the same cycle, the clear wins.
- R4: `dir_dskchg` always equals (`ds_n[0]` AND force0) OR (`ds_n[1]` AND force1) OR `dskchg_n_pin`.
- R5: `dskchg_n_int` is 0 when some drive i has `ds_n[i]`=0 and force i=1. Otherwise it equals `dskchg_n_pin`.
- R6: Bit 2 is the force-write-protect bit. A write stores bit 2 as given (0 or 1), and the stored value reads back in `cfg_rdata[2]`.
- R7: `wrtprt_n_int` is 0 while force-write-protect is 1 and at least one bit of `ds_n` is 0. Otherwise it equals the selected write-protect source.
- R8: With `wp_src_sel`=0, the write-protect source is `wp_n_fdd`. With `wp_src_sel`=1, the source is `wp_n_pport`. The R7 override applies to both sources.
- R9: After reset, all override bits are 0. `cfg_rdata[7:3]` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Override register read value |
| ds_n | input | 2 | Active-low drive selects (synchronized) |
| step_n | input | 1 | Active-low step (synchronized) |
| dskchg_n_pin | input | 1 | External disk-change pin, active low |
| wp_n_fdd | input | 1 | Write-protect pin from the floppy interface |
| wp_n_pport | input | 1 | Write-protect pin from the parallel-port floppy path |
| wp_src_sel | input | 1 | Chooses the write-protect source (1 = parallel port) |
| dskchg_n_int | output | 1 | Disk-change input seen by the controller |
| dir_dskchg | output | 1 | Bit 7 of the digital input register |
| wrtprt_n_int | output | 1 | Write-protect input seen by the controller |

## Verification
Register effects (R1, R2, R3, R6, R9) show in `cfg_rdata` one edge after the write or clear condition. The bench therefore updates its model at the rising edge and compares on the following low phase. Status outputs (R4, R5, R7, R8) are combinational in the same cycle. They are compared a short delay after the inputs change on the falling edge, against the model state held before the next rising edge. Random selects are biased toward a selected drive, so forced states survive long enough to exercise the merge logic.

// File: rtl/fdc_ovr_pkg.sv
package fdc_ovr_pkg;
    localparam int NUM_DRV   = 2;
    localparam int CFG_W     = 8;
    localparam int FWP_BIT   = 2;

    typedef enum logic {
        FC_IDLE   = 1'b0,
        FC_FORCED = 1'b1
    } fchg_state_t;
endpackage

// File: rtl/fdc_ovr_flag.sv
module fdc_ovr_flag
    import fdc_ovr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_cond,
    output logic forced
);
    fchg_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FC_IDLE:   if (set_req && !clr_cond) state_d = FC_FORCED; // SET
            FC_FORCED: if (clr_cond)             state_d = FC_IDLE;   // CLEAR
            default:                             state_d = FC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FC_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        forced = (state_q == FC_FORCED);
    end
endmodule

// File: rtl/fdc_ovr_status.sv
module fdc_ovr_status
    import fdc_ovr_pkg::*;
(
    input  logic [NUM_DRV-1:0] ds_n,
    input  logic [NUM_DRV-1:0] force_chg,
    input  logic               force_wp,
    input  logic               dskchg_n_pin,
    input  logic               wp_n_fdd,
    input  logic               wp_n_pport,
    input  logic               wp_src_sel,
    output logic               dskchg_n_int,
    output logic               dir_dskchg,
    output logic               wrtprt_n_int
);
    logic [NUM_DRV-1:0] dir_term;
    logic [NUM_DRV-1:0] sel_forced;
    logic               any_sel;
    logic               wp_src_n;

    generate
        for (genvar d = 0; d < NUM_DRV; d++) begin : g_drv
            assign dir_term[d]   = ds_n[d] & force_chg[d];
            assign sel_forced[d] = ~ds_n[d] & force_chg[d];
        end
    endgenerate

    always_comb begin
        any_sel      = ~&ds_n;
        wp_src_n     = wp_src_sel ? wp_n_pport : wp_n_fdd;
        dir_dskchg   = (|dir_term) | dskchg_n_pin;
        dskchg_n_int = dskchg_n_pin & ~(|sel_forced);
        wrtprt_n_int = wp_src_n & ~(force_wp & any_sel);
    end
endmodule

// File: rtl/fdc_status_override.sv
module fdc_status_override
    import fdc_ovr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic [1:0]       ds_n,
    input  logic             step_n,
    input  logic             dskchg_n_pin,
    input  logic             wp_n_fdd,
    input  logic             wp_n_pport,
    input  logic             wp_src_sel,
    output logic             dskchg_n_int,
    output logic             dir_dskchg,
    output logic             wrtprt_n_int
);
    logic [NUM_DRV-1:0] force_chg;
    logic               force_wp_q;

    generate
        for (genvar d = 0; d < NUM_DRV; d++) begin : g_flag
            fdc_ovr_flag u_flag (
                .clk      (clk),
                .rst_n    (rst_n),
                .set_req  (cfg_wr & cfg_wdata[d]),
                .clr_cond (step_n & ds_n[d]),
                .forced   (force_chg[d])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      force_wp_q <= 1'b0;
        else if (cfg_wr) force_wp_q <= cfg_wdata[FWP_BIT];
    end

    always_comb begin
        cfg_rdata                     = '0;
        cfg_rdata[NUM_DRV-1:0]        = force_chg;
        cfg_rdata[FWP_BIT]            = force_wp_q;
    end

    fdc_ovr_status u_status (
        .ds_n         (ds_n),
        .force_chg    (force_chg),
        .force_wp     (force_wp_q),
        .dskchg_n_pin (dskchg_n_pin),
        .wp_n_fdd     (wp_n_fdd),
        .wp_n_pport   (wp_n_pport),
        .wp_src_sel   (wp_src_sel),
        .dskchg_n_int (dskchg_n_int),
        .dir_dskchg   (dir_dskchg),
        .wrtprt_n_int (wrtprt_n_int)
    );
endmodule

// File: rtl/fdc_status_override_chk.sv
module fdc_status_override_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_wr,
    input logic [7:0] cfg_wdata,
    input logic [7:0] cfg_rdata,
    input logic [1:0] ds_n,
    input logic       step_n,
    input logic       dskchg_n_pin,
    input logic       wp_n_fdd,
    input logic       wp_n_pport,
    input logic       wp_src_sel,
    input logic       dskchg_n_int,
    input logic       dir_dskchg,
    input logic       wrtprt_n_int
);
    a_r1_set0: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[0] && !(step_n && ds_n[0])) |=> cfg_rdata[0]);

    a_r2_no_sw_clear1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[1] && !(step_n && ds_n[1])) |=> cfg_rdata[1]);

    a_r3_hw_clear0: assert property (@(posedge clk) disable iff (!rst_n)
        (step_n && ds_n[0]) |=> !cfg_rdata[0]);

    a_r4_dir_bit: assert property (@(posedge clk) disable iff (!rst_n)
        dir_dskchg == ((ds_n[0] & cfg_rdata[0]) | (ds_n[1] & cfg_rdata[1]) | dskchg_n_pin));

    a_r5_chg_forced: assert property (@(posedge clk) disable iff (!rst_n)
        ((!ds_n[0] && cfg_rdata[0]) || (!ds_n[1] && cfg_rdata[1])) |-> !dskchg_n_int);

    a_r7_wp_forced: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[2] && ds_n != 2'b11) |-> !wrtprt_n_int);

    a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[7:3] == 5'd0);
endmodule

bind fdc_status_override fdc_status_override_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .ds_n(ds_n), .step_n(step_n),
    .dskchg_n_pin(dskchg_n_pin), .wp_n_fdd(wp_n_fdd), .wp_n_pport(wp_n_pport),
    .wp_src_sel(wp_src_sel), .dskchg_n_int(dskchg_n_int),
    .dir_dskchg(dir_dskchg), .wrtprt_n_int(wrtprt_n_int)
);

// File: tb/tb_fdc_status_override.sv
module tb_fdc_status_override;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic [1:0] ds_n = 2'b11;
    logic       step_n = 1'b1;
    logic       dskchg_n_pin = 1'b1;
    logic       wp_n_fdd = 1'b1;
    logic       wp_n_pport = 1'b1;
    logic       wp_src_sel = 1'b0;
    logic       dskchg_n_int, dir_dskchg, wrtprt_n_int;

    int n_chk = 0;
    int n_fail = 0;
    logic m_f0 = 0, m_f1 = 0, m_wp = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fdc_status_override dut (.*);

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic exp_dir();
        return (ds_n[0] & m_f0) | (ds_n[1] & m_f1) | dskchg_n_pin;
    endfunction
    function automatic logic exp_chg();
        return dskchg_n_pin & ~((~ds_n[0] & m_f0) | (~ds_n[1] & m_f1));
    endfunction
    function automatic logic exp_wp();
        logic src;
        src = wp_src_sel ? wp_n_pport : wp_n_fdd;
        return src & ~(m_wp & (ds_n != 2'b11));
    endfunction

    // inputs already applied at negedge; check outputs, then advance one edge
    task automatic cycle();
        #1;
        check("R9", {5'b0, cfg_rdata[2:0]} ^ cfg_rdata, 8'h00);
        check("R1/R2/R3/R6", cfg_rdata, {5'b0, m_wp, m_f1, m_f0});
        check("R4", {7'b0, dir_dskchg}, {7'b0, exp_dir()});
        check("R5", {7'b0, dskchg_n_int}, {7'b0, exp_chg()});
        check(wp_src_sel ? "R8" : "R7", {7'b0, wrtprt_n_int}, {7'b0, exp_wp()});
        @(posedge clk);
        if (step_n & ds_n[0]) m_f0 = 0; else if (cfg_wr & cfg_wdata[0]) m_f0 = 1;
        if (step_n & ds_n[1]) m_f1 = 0; else if (cfg_wr & cfg_wdata[1]) m_f1 = 1;
        if (cfg_wr) m_wp = cfg_wdata[2];
        @(negedge clk);
    endtask

    task automatic drive(input logic wr, input logic [7:0] wd, input logic [1:0] ds,
                         input logic st);
        cfg_wr = wr; cfg_wdata = wd; ds_n = ds; step_n = st;
        cycle();
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (2) @(negedge clk);
        #1 check("R9 reset", cfg_rdata, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: set drive 0 while drive 0 selected, step high
        drive(1, 8'h01, 2'b10, 1);
        drive(0, 8'h00, 2'b10, 1);
        check("R1 drive0 set", cfg_rdata, 8'h01);
        // R2: write 0 leaves it; R6 sets write-protect force
        drive(1, 8'h04, 2'b10, 1);
        drive(0, 8'h00, 2'b10, 1);
        check("R2/R6 held", cfg_rdata, 8'h05);
        // R1: set drive 1 while step low (no clear), drive 1 deselected
        drive(1, 8'h06, 2'b11, 0);
        drive(0, 8'h00, 2'b11, 0);
        check("R1 drive1 set", cfg_rdata, 8'h07);
        // R3: clear beats set for drive 0
        drive(1, 8'h07, 2'b01, 1);
        drive(0, 8'h00, 2'b00, 0);
        check("R3 clear priority", cfg_rdata, 8'h06);
        // R8: parallel-port source
        wp_src_sel = 1; wp_n_pport = 1; wp_n_fdd = 0;
        drive(0, 8'h00, 2'b11, 0);
        drive(0, 8'h00, 2'b01, 0);
        // R6 write 0 clears fwp
        drive(1, 8'h00, 2'b00, 0);
        drive(0, 8'h00, 2'b00, 0);
        check("R6 fwp cleared", cfg_rdata, 8'h02);
        // random phase
        for (int i = 0; i < 600; i++) begin
            logic [1:0] ds;
            ds = ($urandom_range(0, 3) == 0) ? 2'b11 : 2'($urandom_range(0, 2));
            dskchg_n_pin = 1'($urandom);
            wp_n_fdd     = 1'($urandom);
            wp_n_pport   = 1'($urandom);
            wp_src_sel   = 1'($urandom);
            drive(($urandom_range(0, 3) == 0), 8'($urandom), ds,
                  ($urandom_range(0, 2) == 0));
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule